// File: doc/BRIEF.md
# CRC-4 Command Frame Builder

This block sits between a contactless-card reader's control logic and its bit-level transmitter and receiver. It builds the raw command word that the reader sends to a small memory card, and it checks the words the card sends back. Bit serialisation, whitening and radio timing are handled elsewhere. The block only assembles and checks bit vectors, and it reports how many bits of the assembled vector are meaningful.

A request is one `start` pulse together with an operation code, a card type, a byte address, and either a data byte or a received reply. The card type selects one of three address widths. The address width fixes the command width (address width + 1) and the card's memory size. A read command completes on the clock edge that samples `start`. A write command and a reply check first run a 4-bit CRC over a packed word, one bit per clock, so their result arrives later. Every completion is marked by a one-cycle `done`. The results then stay on the outputs until the next completion.

Illegal requests complete at once with `err` set and no CRC run. These are: an unknown card type, the reserved operation code, an address outside the card, and a write to the protected low addresses.

Top module: `cfb_frame_builder`

## Requirements
- R1: Card type 0x0D gives address width 5, command width 6 and 22 bytes. Type 0x1D gives 8, 9 and 256 bytes. Type 0x3D gives 10, 11 and 1024 bytes. Any other type completes with `err`=1, `frame`=0, `frame_len`=0 and `crc_ok`=0.
- R2: Operation 2'b00 (read command) gives `frame` = address shifted left by one with bit 0 = 1, zero above the command width, and `frame_len` = command width. `done` rises on the edge that samples `start`.
- R3: The CRC is 4 bits. It starts at 0x5 and consumes the input LSB first. Each step takes the state bit 0 XOR the input bit as feedback, shifts the state right by one, and XORs in 0xC when the feedback is 1. There is no final XOR. The input word is the data byte shifted left by the command width, ORed with the command word, for 8 + command width bits.
- R4: Operation 2'b01 (write command) gives a `frame` with these fields:
  - bits 0 to address width: the address shifted left by one, with bit 0 = 0;
  - from bit (address width + 1): the data byte;
  - from bit (address width + 9): the CRC nibble (R3).

  `frame_len` = address width + 13.
- R5: Operation 2'b10 (reply check) gives `rdata` = `reply[7:0]`, `frame`=0 and `frame_len`=0. It sets `crc_ok`=1 exactly when `reply[11:8]` equals the R3 CRC of that byte with the read command word of the given address.
- R6: An address at or beyond the card's memory size completes with `err`=1, for any operation.
- R7: A write to addresses 0 through 4 completes with `err`=1. Reads and reply checks of those addresses are accepted.
- R8: Operation 2'b11 is reserved and completes with `err`=1.
- R9: A write or reply check raises `done` on the edge numbered 8 + command width + 2, counting the edge that samples `start` as 1. `busy` is high in between, and `done` is a one-cycle pulse.
- R10: `start` is ignored while `busy` is high. The running request completes unchanged.
- R11: `frame`, `frame_len`, `err`, `rdata` and `crc_ok` change only on a completion and hold their values between completions.
- R12: During reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, sampled while idle |
| op | input | 2 | 00 read command, 01 write command, 10 reply check, 11 reserved |
| card_type | input | 8 | Card type code |
| addr | input | 10 | Byte address |
| wdata | input | 8 | Byte to write |
| reply | input | 12 | Received card reply: CRC in [11:8], data in [7:0] |
| busy | output | 1 | CRC running |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request rejected |
| frame | output | 23 | Assembled command bits, LSB is the first bit on air |
| frame_len | output | 5 | Number of valid bits in `frame` |
| rdata | output | 8 | Data byte of the last checked reply |
| crc_ok | output | 1 | Last checked reply had a matching CRC |

## Verification
The bench builds the block with its default geometry: a 10-bit maximum address, a 23-bit frame and the write-protect limit at address 4. All three card widths can therefore be exercised in one build, including the last byte of the largest card (address 1023) and the 23-bit write frame that fills every output bit. Keeping the limit at 4 puts the protected and first writable addresses (4 and 5) side by side. With these values the serial CRC runs 14, 17 or 19 steps, so the latency of every card type can be counted edge by edge.

// File: rtl/cfb_pkg.sv
// Package: shared constants and types of the CRC-4 command frame builder.
// Assumes a maximum address width of 10 bits; every other width derives from it.
package cfb_pkg;
    localparam int MAX_AW   = 10;
    localparam int CMD_MAX  = MAX_AW + 1;
    localparam int CRC_IN_W = CMD_MAX + 8;
    localparam int FRAME_W  = MAX_AW + 13;
    localparam int LEN_W    = $clog2(FRAME_W + 1);
    localparam int MEM_W    = MAX_AW + 1;

    localparam logic [3:0] CRC_POLY = 4'hC;
    localparam logic [3:0] CRC_SEED = 4'h5;

    typedef enum logic [1:0] {
        OP_RD_CMD = 2'b00,
        OP_WR_CMD = 2'b01,
        OP_CHK    = 2'b10,
        OP_RSVD   = 2'b11
    } op_e;

    typedef struct packed {
        logic             ok;
        logic [3:0]       aw;
        logic [MEM_W-1:0] mem_size;
    } geom_t;
endpackage

// File: rtl/cfb_card_decode.sv
// Module: maps a card type code to its address width and memory size.
// Purely combinational. Unknown codes return ok=0 with a zero geometry.
module cfb_card_decode
    import cfb_pkg::*;
(
    input  logic [7:0] card_type,
    output geom_t      geom
);
    // Purpose: table lookup of the three supported card geometries.
    always_comb begin
        geom = '0;
        unique case (card_type)
            8'h0D: geom = '{ok: 1'b1, aw: 4'd5,  mem_size: MEM_W'(22)};
            8'h1D: geom = '{ok: 1'b1, aw: 4'd8,  mem_size: MEM_W'(256)};
            8'h3D: geom = '{ok: 1'b1, aw: 4'd10, mem_size: MEM_W'(1024)};
            default: geom = '0;
        endcase
    end
endmodule

// File: rtl/cfb_crc4_serial.sv
// Module: bit-serial reflected CRC-4, one input bit per clock, LSB first.
// Assumes load is pulsed only while idle; nbits must not exceed DW.
module cfb_crc4_serial #(
    parameter int         DW    = 19,
    parameter int         CNT_W = $clog2(DW + 1),
    parameter logic [3:0] POLY  = 4'hC,
    parameter logic [3:0] SEED  = 4'h5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DW-1:0]    din,
    input  logic [CNT_W-1:0] nbits,
    output logic             busy,
    output logic             done,
    output logic [3:0]       crc
);
    logic [DW-1:0]    word_q;
    logic [CNT_W-1:0] left_q;
    logic [3:0]       nxt;
    logic             fb;

    // Purpose: one LFSR step on the current low input bit.
    always_comb begin
        fb  = crc[0] ^ word_q[0];
        nxt = crc >> 1;
        if (fb) nxt = nxt ^ POLY;
    end

    // Purpose: load the word, then consume one bit per cycle until empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc    <= '0;
            word_q <= '0;
            left_q <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                crc    <= SEED;
                word_q <= din;
                left_q <= nbits;
                busy   <= (nbits != '0);
                done   <= (nbits == '0);
            end else if (busy) begin
                crc    <= nxt;
                word_q <= word_q >> 1;
                left_q <= left_q - 1'b1;
                if (left_q == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cfb_frame_builder.sv
// Module: top of the CRC-4 command frame builder. Validates a request,
// emits read commands at once, and runs the serial CRC for write frames
// and reply checks. Assumes inputs are stable in the cycle start is high.
module cfb_frame_builder
    import cfb_pkg::*;
#(
    parameter int PROT_LAST = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         op,
    input  logic [7:0]         card_type,
    input  logic [MAX_AW-1:0]  addr,
    input  logic [7:0]         wdata,
    input  logic [11:0]        reply,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [FRAME_W-1:0] frame,
    output logic [LEN_W-1:0]   frame_len,
    output logic [7:0]         rdata,
    output logic               crc_ok
);
    typedef enum logic {S_IDLE, S_WAIT} state_e;

    state_e              state_q;
    op_e                 op_in, op_q;
    geom_t               geom;
    logic [3:0]          cmdw;
    logic [CMD_MAX-1:0]  cmd_in;
    logic                bad, accept, crc_load;
    logic [7:0]          byte_in;
    logic [CRC_IN_W-1:0] crc_word;
    logic [LEN_W-1:0]    crc_nbits;
    logic                crc_busy, crc_done;
    logic [3:0]          crc_val;
    logic [3:0]          aw_q;
    logic [CMD_MAX-1:0]  cmd_q;
    logic [7:0]          byte_q;
    logic [3:0]          rx_crc_q;
    logic [FRAME_W-1:0]  wr_frame;

    cfb_card_decode u_dec (
        .card_type (card_type),
        .geom      (geom)
    );

    // Purpose: request decode, legality check and CRC input packing.
    always_comb begin
        op_in     = op_e'(op);
        cmdw      = geom.aw + 4'd1;
        cmd_in    = {addr, (op_in == OP_WR_CMD) ? 1'b0 : 1'b1};
        bad       = !geom.ok
                  || (op_in == OP_RSVD)
                  || ({1'b0, addr} >= geom.mem_size)
                  || ((op_in == OP_WR_CMD) && (addr <= MAX_AW'(PROT_LAST)));
        accept    = (state_q == S_IDLE) && start;
        crc_load  = accept && !bad && (op_in != OP_RD_CMD);
        byte_in   = (op_in == OP_WR_CMD) ? wdata : reply[7:0];
        crc_word  = (CRC_IN_W'(byte_in) << cmdw) | CRC_IN_W'(cmd_in);
        crc_nbits = LEN_W'(cmdw) + LEN_W'(8);
    end

    cfb_crc4_serial #(
        .DW    (CRC_IN_W),
        .CNT_W (LEN_W),
        .POLY  (CRC_POLY),
        .SEED  (CRC_SEED)
    ) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (crc_load),
        .din   (crc_word),
        .nbits (crc_nbits),
        .busy  (crc_busy),
        .done  (crc_done),
        .crc   (crc_val)
    );

    // Purpose: place command, data byte and CRC nibble into a write frame.
    always_comb begin
        wr_frame = FRAME_W'(cmd_q)
                 | (FRAME_W'(byte_q) << ({1'b0, aw_q} + 5'd1))
                 | (FRAME_W'(crc_val) << ({1'b0, aw_q} + 5'd9));
    end

    // Purpose: request sequencing and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            op_q      <= OP_RD_CMD;
            aw_q      <= '0;
            cmd_q     <= '0;
            byte_q    <= '0;
            rx_crc_q  <= '0;
            done      <= 1'b0;
            err       <= 1'b0;
            frame     <= '0;
            frame_len <= '0;
            rdata     <= '0;
            crc_ok    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                S_IDLE: if (accept) begin
                    op_q     <= op_in;
                    aw_q     <= geom.aw;
                    cmd_q    <= cmd_in;
                    byte_q   <= byte_in;
                    rx_crc_q <= reply[11:8];
                    if (bad) begin
                        done      <= 1'b1;
                        err       <= 1'b1;
                        frame     <= '0;
                        frame_len <= '0;
                        rdata     <= '0;
                        crc_ok    <= 1'b0;
                    end else if (op_in == OP_RD_CMD) begin
                        done      <= 1'b1;
                        err       <= 1'b0;
                        frame     <= FRAME_W'(cmd_in);
                        frame_len <= LEN_W'(cmdw);
                        rdata     <= '0;
                        crc_ok    <= 1'b0;
                    end else begin
                        state_q <= S_WAIT;
                    end
                end
                S_WAIT: if (crc_done) begin
                    state_q <= S_IDLE;
                    done    <= 1'b1;
                    err     <= 1'b0;
                    if (op_q == OP_WR_CMD) begin
                        frame     <= wr_frame;
                        frame_len <= {1'b0, aw_q} + 5'd13;
                        rdata     <= '0;
                        crc_ok    <= 1'b0;
                    end else begin
                        frame     <= '0;
                        frame_len <= '0;
                        rdata     <= byte_q;
                        crc_ok    <= (crc_val == rx_crc_q);
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign busy = (state_q == S_WAIT) || crc_busy;
endmodule

// File: rtl/cfb_frame_builder_chk.sv
// Module: property checker bound to the frame builder top.
// Observes ports only; assumes the synchronous active-low reset.
module cfb_frame_builder_chk
    import cfb_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic               err,
    input logic [FRAME_W-1:0] frame,
    input logic [LEN_W-1:0]   frame_len,
    input logic [7:0]         rdata,
    input logic               crc_ok
);
    logic [FRAME_W-1:0] wr_field;

    // Purpose: extract the address field of a write frame from its length.
    always_comb begin
        wr_field = (frame >> 1) & ((FRAME_W'(1) << (frame_len - 5'd13)) - FRAME_W'(1));
    end

    p_busy_no_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
    p_fell_busy_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    p_err_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (frame == '0 && frame_len == '0 && !crc_ok));
    p_len_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (frame_len inside {5'd0, 5'd6, 5'd9, 5'd11, 5'd18, 5'd21, 5'd23}));
    p_crcok_only_chk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && frame_len != '0) |-> !crc_ok);
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(frame) && $stable(frame_len) && $stable(err)
                   && $stable(rdata) && $stable(crc_ok)));
    p_wr_prot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && frame_len >= 5'd18) |-> (wr_field > FRAME_W'(4)));
endmodule

bind cfb_frame_builder cfb_frame_builder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .frame     (frame),
    .frame_len (frame_len),
    .rdata     (rdata),
    .crc_ok    (crc_ok)
);

// File: tb/tb_cfb_frame_builder.sv
// Bench: directed scenarios for the CRC-4 command frame builder.
module tb_cfb_frame_builder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [7:0]  card_type = 8'h0;
    logic [9:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [11:0] reply = '0;
    logic        busy, done, err, crc_ok;
    logic [22:0] frame;
    logic [4:0]  frame_len;
    logic [7:0]  rdata;

    int tests = 0;
    int fails = 0;
    int last_edges;
    logic last_busy;

    cfb_frame_builder dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .card_type(card_type),
        .addr(addr), .wdata(wdata), .reply(reply), .busy(busy), .done(done),
        .err(err), .frame(frame), .frame_len(frame_len), .rdata(rdata), .crc_ok(crc_ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference CRC from R3.
    function automatic logic [3:0] ref_crc(input logic [31:0] w, input int n);
        logic [3:0] s;
        s = 4'h5;
        for (int i = 0; i < n; i++) begin
            logic fb;
            fb = s[0] ^ w[i];
            s = s >> 1;
            if (fb) s = s ^ 4'hC;
        end
        return s;
    endfunction

    // Address width from R1 (0 = unknown type).
    function automatic int ref_aw(input logic [7:0] t);
        case (t)
            8'h0D: return 5;
            8'h1D: return 8;
            8'h3D: return 10;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Issue one request and wait for done; counts edges incl. the sampling edge.
    task automatic run_op(input logic [1:0] o, input logic [7:0] t, input logic [9:0] a,
                          input logic [7:0] d, input logic [11:0] r);
        @(negedge clk);
        op = o; card_type = t; addr = a; wdata = d; reply = r; start = 1'b1;
        @(posedge clk);
        last_edges = 1;
        @(negedge clk);
        start = 1'b0;
        last_busy = busy;
        while (!done && last_edges < 200) begin
            @(posedge clk);
            last_edges++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        check("R12", "done", done, 0);
        check("R12", "busy", busy, 0);
        check("R12", "err", err, 0);
        check("R12", "frame", frame, 0);
        check("R12", "frame_len", frame_len, 0);
        check("R12", "rdata", rdata, 0);
        check("R12", "crc_ok", crc_ok, 0);
    endtask

    task automatic t_read(input logic [7:0] t, input logic [9:0] a);
        int aw;
        aw = ref_aw(t);
        run_op(2'b00, t, a, 8'h00, 12'h0);
        check("R2", "read latency", last_edges, 1);
        check("R2", "read err", err, 0);
        check("R2", "read frame", frame, (32'(a) << 1) | 1);
        check("R1", "read len", frame_len, aw + 1);
    endtask

    task automatic t_write(input logic [7:0] t, input logic [9:0] a, input logic [7:0] d);
        int aw;
        logic [31:0] cmd, exp;
        logic [3:0] c;
        aw  = ref_aw(t);
        cmd = 32'(a) << 1;
        c   = ref_crc((32'(d) << (aw + 1)) | cmd, aw + 9);
        exp = cmd | (32'(d) << (aw + 1)) | (32'(c) << (aw + 9));
        run_op(2'b01, t, a, d, 12'h0);
        check("R9", "write latency", last_edges, aw + 1 + 8 + 2);
        check("R9", "busy while running", last_busy, 1);
        check("R4", "write err", err, 0);
        check("R4", "write frame (R3 crc)", frame, exp);
        check("R4", "write len", frame_len, aw + 13);
        @(negedge clk);
        check("R9", "done one cycle", done, 0);
    endtask

    task automatic t_reply(input logic [7:0] t, input logic [9:0] a, input logic [7:0] d, input logic corrupt);
        int aw;
        logic [3:0] c;
        aw = ref_aw(t);
        c  = ref_crc((32'(d) << (aw + 1)) | (32'(a) << 1) | 1, aw + 9);
        if (corrupt) c = c ^ 4'h8;
        run_op(2'b10, t, a, 8'h00, {c, d});
        check("R9", "check latency", last_edges, aw + 1 + 8 + 2);
        check("R5", "rdata", rdata, d);
        check("R5", "crc_ok", crc_ok, !corrupt);
        check("R5", "frame zero", frame, 0);
        check("R5", "len zero", frame_len, 0);
    endtask

    task automatic t_reject(input string req, input logic [1:0] o, input logic [7:0] t, input logic [9:0] a);
        run_op(o, t, a, 8'h5A, 12'h0);
        check(req, "reject latency", last_edges, 1);
        check(req, "err", err, 1);
        check(req, "frame", frame, 0);
        check(req, "len", frame_len, 0);
        check(req, "crc_ok", crc_ok, 0);
    endtask

    task automatic t_busy_ignore;
        logic [3:0] c;
        c = ref_crc((32'h3C << 9) | (32'd100 << 1), 17);
        @(negedge clk);
        op = 2'b01; card_type = 8'h1D; addr = 10'd100; wdata = 8'h3C; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        op = 2'b00; card_type = 8'h0D; addr = 10'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10", "no done from ignored start", done, 0);
        for (int i = 0; i < 40 && !done; i++) @(negedge clk);
        check("R10", "first request frame", frame, (32'd100 << 1) | (32'h3C << 9) | (32'(c) << 17));
        check("R10", "first request len", frame_len, 21);
    endtask

    task automatic t_hold;
        logic [22:0] f;
        logic [4:0]  l;
        run_op(2'b00, 8'h1D, 10'd200, 8'h00, 12'h0);
        f = frame; l = frame_len;
        @(negedge clk);
        op = 2'b01; card_type = 8'h3D; addr = 10'd9; wdata = 8'hFF; reply = 12'hFFF;
        for (int i = 0; i < 5; i++) @(negedge clk);
        check("R11", "frame held", frame, f);
        check("R11", "len held", frame_len, l);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_read(8'h0D, 10'd0);
        t_read(8'h0D, 10'd21);
        t_read(8'h1D, 10'd255);
        t_read(8'h3D, 10'd1023);
        t_write(8'h0D, 10'd5, 8'hA5);
        t_write(8'h1D, 10'd77, 8'h00);
        t_write(8'h3D, 10'd1023, 8'hFF);
        t_write(8'h3D, 10'd513, 8'h96);
        t_reply(8'h0D, 10'd3, 8'h5C, 1'b0);
        t_reply(8'h1D, 10'd130, 8'hE1, 1'b1);
        t_reply(8'h3D, 10'd700, 8'h0F, 1'b0);
        t_reject("R1", 2'b00, 8'h2D, 10'd1);
        t_reject("R6", 2'b00, 8'h0D, 10'd22);
        t_reject("R6", 2'b10, 8'h1D, 10'd256);
        t_reject("R7", 2'b01, 8'h3D, 10'd4);
        t_reject("R7", 2'b01, 8'h0D, 10'd0);
        t_reject("R8", 2'b11, 8'h1D, 10'd10);
        t_busy_ignore();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule